// File: doc/BRIEF.md
# Audio Output Control Sequencer

This block sets the operating state of a digital PWM audio output stage. Power-down, reset and mute requests come in on separate inputs. Three serial-format select pins and a one-cycle frame strobe (one pulse per audio frame period) complete the inputs. From these the block drives three outputs: an active-low error flag, a hard-mute control for the differential PWM pairs, and an enable for the audio datapath.

After the power-down and reset requests are both released, the block counts a fixed number of frame periods to initialize. It then enters the operational state and releases the error flag. Mute can be applied and removed in the operational state without another initialization. A change on any format-select pin is synchronized and detected, and it starts the initialization over. A reset or power-down request returns the block to its held state at any time.

When `hard_mute` is 1, the PWM driver ties every positive output low and every negative output high.

Top module: `aud_out_seq`

## Requirements
- R1: While `arst_n` is low, and in the first cycle after it rises with `rst_req` or `pd_req` high, the outputs are `err_n`=0, `hard_mute`=1, `dp_en`=0.
- R2: `hard_mute` is 1 in every state except unmuted operation. A value of 1 means positive PWM outputs are low and negative outputs are high.
- R3: Initialization begins only when both `rst_req` and `pd_req` are low. The release order does not matter, and the later release starts it. During initialization `dp_en`=1, `err_n`=0 and `hard_mute`=1.
- R4: Initialization ends on exactly INIT_FRAMES (default 4224) sampled `frame_stb` pulses. In the cycle after the clock edge that samples the last pulse, `err_n`=1, and `hard_mute`=0 if `mute_req` is low.
- R5: In the operational state, raising `mute_req` sets `hard_mute`=1 one cycle later while `err_n` stays 1. Lowering it clears `hard_mute` one cycle later, with no new initialization.
- R6: If `mute_req` is high when initialization ends, the block enters operation muted (`err_n`=1, `hard_mute`=1).
- R7: A change of any single bit of `fmt_sel` during initialization or operation restarts the sequence. Within FMT_SYNC+1 cycles the outputs become `err_n`=0, `hard_mute`=1, `dp_en`=1, and a full INIT_FRAMES count is needed again.
- R8: `rst_req` or `pd_req` high in any state gives `err_n`=0, `hard_mute`=1, `dp_en`=0 one cycle later.
- R9: `frame_stb` has no effect in the held state or in operation, and a `fmt_sel` change while held does not shorten or lengthen the next initialization.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| pd_req | input | 1 | Power-down request, active high |
| rst_req | input | 1 | Reset request, active high |
| mute_req | input | 1 | Mute request, active high |
| fmt_sel | input | FMT_W | Serial-format select pins, asynchronous |
| frame_stb | input | 1 | One-cycle pulse per audio frame period |
| err_n | output | 1 | Error flag, low until operation is reached |
| hard_mute | output | 1 | 1 forces positive PWM outputs low and negative outputs high |
| dp_en | output | 1 | Datapath enable, high outside the held state |

## Verification
The assertions check four things on every cycle. A held request leads to the held outputs on the next cycle. The error flag rises only after the counter has reported its final frame. A mute request in operation mutes without dropping the error flag. A detected format change restarts initialization, and the frame counter is zero outside initialization. Only the bench scenarios can show the exact frame count and the independence from release order. They also cover mute pending at the end of initialization, the restart on each individual format bit, and the ignored strobes and held-state format changes.

// File: rtl/aos_pkg.sv
package aos_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_MUTE = 2'd3
  } aos_state_e;

  // final frame of the initialization window
  function automatic logic cnt_at_last(input logic [31:0] cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

  // error flag is released only in the two operational states
  function automatic logic err_n_of(input aos_state_e st);
    return (st == ST_RUN) || (st == ST_MUTE);
  endfunction

  // outputs are silenced everywhere but unmuted operation
  function automatic logic hmute_of(input aos_state_e st);
    return st != ST_RUN;
  endfunction

  // datapath runs whenever no hold request is active
  function automatic logic dpen_of(input aos_state_e st);
    return st != ST_HOLD;
  endfunction

endpackage

// File: rtl/aos_fmt_watch.sv
module aos_fmt_watch #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] fmt_async,
  output logic         chg
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             ref_q;
  logic [STAGES:0]          prime_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg_q   <= '0;
      ref_q   <= '0;
      prime_q <= '0;
    end else begin
      stg_q[0] <= fmt_async;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      ref_q   <= stg_q[STAGES-1];
      prime_q <= {prime_q[STAGES-1:0], 1'b1};
    end
  end

  // compare only once the pipeline holds real pin values
  assign chg = prime_q[STAGES] && (stg_q[STAGES-1] != ref_q);

endmodule

// File: rtl/aos_frame_cnt.sv
module aos_frame_cnt #(
  parameter int INIT_FRAMES = 4224,
  localparam int CW = (INIT_FRAMES > 1) ? $clog2(INIT_FRAMES) : 1
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          frame_stb,
  output logic [CW-1:0] cnt,
  output logic          last
);
  import aos_pkg::*;

  assign last = run && frame_stb && cnt_at_last(32'(cnt), INIT_FRAMES);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (run && frame_stb)  cnt <= last ? '0 : cnt + CW'(1);
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
    32'(cnt) < INIT_FRAMES);

endmodule

// File: rtl/aos_ctrl_fsm.sv
module aos_ctrl_fsm (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                hold,
  input  logic                fmt_chg,
  input  logic                mute,
  input  logic                init_last,
  output aos_pkg::aos_state_e state
);
  import aos_pkg::*;

  aos_state_e nxt;

  always_comb begin
    nxt = state;
    if (hold) nxt = ST_HOLD;
    else begin
      unique case (state)
        ST_HOLD: nxt = ST_INIT;
        ST_INIT: if (fmt_chg) nxt = ST_INIT;
                 else if (init_last) nxt = mute ? ST_MUTE : ST_RUN;
        ST_RUN:  if (fmt_chg) nxt = ST_INIT;
                 else if (mute) nxt = ST_MUTE;
        ST_MUTE: if (fmt_chg) nxt = ST_INIT;
                 else if (!mute) nxt = ST_RUN;
        default: nxt = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state <= ST_HOLD;
    else         state <= nxt;
  end

  // R6
  mute_at_end_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state == ST_INIT && init_last && mute && !hold && !fmt_chg) |=> state == ST_MUTE);

endmodule

// File: rtl/aud_out_seq.sv
module aud_out_seq #(
  parameter int INIT_FRAMES = 4224,
  parameter int FMT_W       = 3,
  parameter int FMT_SYNC    = 2,
  localparam int CW = (INIT_FRAMES > 1) ? $clog2(INIT_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             pd_req,
  input  logic             rst_req,
  input  logic             mute_req,
  input  logic [FMT_W-1:0] fmt_sel,
  input  logic             frame_stb,
  output logic             err_n,
  output logic             hard_mute,
  output logic             dp_en
);
  import aos_pkg::*;

  aos_state_e    state;
  logic          hold_in;
  logic          fmt_chg;
  logic          in_init;
  logic          init_last;
  logic          cnt_clr;
  logic [CW-1:0] frame_cnt;

  assign hold_in = rst_req || pd_req;
  assign in_init = (state == ST_INIT);
  assign cnt_clr = !in_init || fmt_chg;

  aos_fmt_watch #(.W(FMT_W), .STAGES(FMT_SYNC)) u_fmt (
    .clk(clk), .arst_n(arst_n), .fmt_async(fmt_sel), .chg(fmt_chg)
  );

  aos_frame_cnt #(.INIT_FRAMES(INIT_FRAMES)) u_cnt (
    .clk(clk), .arst_n(arst_n), .clr(cnt_clr), .run(in_init),
    .frame_stb(frame_stb), .cnt(frame_cnt), .last(init_last)
  );

  aos_ctrl_fsm u_fsm (
    .clk(clk), .arst_n(arst_n), .hold(hold_in), .fmt_chg(fmt_chg),
    .mute(mute_req), .init_last(init_last), .state(state)
  );

  assign err_n     = err_n_of(state);
  assign hard_mute = hmute_of(state);
  assign dp_en     = dpen_of(state);

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!arst_n)
    hold_in |=> (!err_n && hard_mute && !dp_en));

  // R4
  op_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(err_n) |-> $past(init_last));

  // R5
  mute_enter_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (err_n && !hard_mute && mute_req && !hold_in && !fmt_chg) |=> (err_n && hard_mute));

  // R7
  fmt_restart_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (fmt_chg && !hold_in && dp_en) |=> (!err_n && hard_mute && dp_en));

  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !in_init |=> frame_cnt == '0);

endmodule

// File: tb/aud_out_seq_tb.sv
module aud_out_seq_tb;

  localparam int NF = 4224;

  logic       clk = 1'b0;
  logic       arst_n, pd_req, rst_req, mute_req, frame_stb;
  logic [2:0] fmt_sel;
  logic       err_n, hard_mute, dp_en;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  aud_out_seq #(.INIT_FRAMES(NF)) u_dut (
    .clk(clk), .arst_n(arst_n), .pd_req(pd_req), .rst_req(rst_req),
    .mute_req(mute_req), .fmt_sel(fmt_sel), .frame_stb(frame_stb),
    .err_n(err_n), .hard_mute(hard_mute), .dp_en(dp_en)
  );

  // {pd, rst, mute, exp err_n, exp hard_mute, exp dp_en}
  localparam logic [5:0] VEC [6] = '{
    6'b001_111, 6'b000_101, 6'b001_111, 6'b000_101, 6'b010_010, 6'b100_010
  };

  task automatic chk(input string req, input logic [2:0] exp);
    checks++;
    if ({err_n, hard_mute, dp_en} !== exp) begin
      errors++;
      $display("FAIL %s: {err_n,hard_mute,dp_en} actual %b expected %b", req, {err_n, hard_mute, dp_en}, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frames(input int n);
    repeat (n) begin
      @(negedge clk) frame_stb = 1'b1;
      @(negedge clk) frame_stb = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    arst_n = 0; pd_req = 1; rst_req = 1; mute_req = 0; frame_stb = 0; fmt_sel = 3'b000;
    cyc(3);
    chk("R1 in reset", 3'b010);
    @(negedge clk) arst_n = 1;
    cyc(1);
    chk("R1 after reset", 3'b010);
    frames(10);
    chk("R9 strobes while held", 3'b010);
    @(negedge clk) fmt_sel = 3'b101;
    cyc(5);
    @(negedge clk) rst_req = 0;
    cyc(3);
    chk("R3 pd still high", 3'b010);
    @(negedge clk) pd_req = 0;
    cyc(1);
    chk("R3 init after last release", 3'b011);
    chk("R2 muted in init", 3'b011);
    frames(NF - 1);
    chk("R9 held fmt change, count not done", 3'b011);
    frames(1);
    chk("R4 operational after full count", 3'b101);

    // table of mute and hold transitions from operation
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) {pd_req, rst_req, mute_req} = VEC[i][5:3];
      cyc(2);
      chk(i < 4 ? "R5 mute toggle" : "R8 hold request", VEC[i][2:0]);
    end

    // pd released first, rst last, mute pending
    @(negedge clk) begin pd_req = 1; rst_req = 1; mute_req = 1; end
    @(negedge clk) pd_req = 0;
    cyc(2);
    chk("R3 rst still high", 3'b010);
    @(negedge clk) rst_req = 0;
    cyc(1);
    chk("R3 release order", 3'b011);
    frames(NF);
    chk("R6 muted operation", 3'b111);
    @(negedge clk) mute_req = 0;
    cyc(1);
    chk("R5 unmute without init", 3'b101);
    frames(5);
    chk("R9 strobes in operation", 3'b101);

    // each format bit restarts the sequence
    for (int b = 0; b < 3; b++) begin
      @(negedge clk) fmt_sel[b] = ~fmt_sel[b];
      cyc(4);
      chk("R7 format bit restart", 3'b011);
      frames(NF - 1);
      chk("R7 full recount needed", 3'b011);
      frames(1);
      chk("R7 operational again", 3'b101);
    end

    // format change during initialization restarts the count
    @(negedge clk) rst_req = 1;
    @(negedge clk) rst_req = 0;
    frames(100);
    @(negedge clk) fmt_sel = ~fmt_sel;
    cyc(4);
    frames(NF - 1);
    chk("R7 restart mid init", 3'b011);
    frames(1);
    chk("R7 run after restart", 3'b101);

    @(negedge clk) pd_req = 1;
    cyc(1);
    chk("R8 power-down in run", 3'b010);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule